// File: doc/BRIEF.md
# Two-Slot Elastic Buffer

This block is one pipeline stage on a channel that carries tokens under valid/stop flow control. On each side of the stage, a cycle is one of three kinds. It is idle when valid is low. It is a transfer when valid is high and stop is low. It is a retry when both are high. During a retry the sender must hold its data and keep valid asserted until the transfer happens. Placing the stage on a long route splits both the forward data wires and the backward stop path into register-bounded segments.

The stage holds up to two tokens. The stop it sends upstream comes from a flop and never depends directly on the stop it receives from downstream. The cost of that register is one cycle of delay before the sender learns the stage is full. The second slot absorbs the token the sender launches during that cycle, so no token is lost under back-pressure. Tokens leave in the order they arrived. A token accepted into an empty stage is offered downstream on the following cycle.

Top module: `elastic_buf2`

## Requirements
- R1: After synchronous reset, out_valid is 0 and in_stop is 0.
- R2: A token accepted (in_valid=1, in_stop=0 at a rising edge) into an empty stage appears on out_data with out_valid=1 right after that edge.
- R3: Tokens leave in the exact order they were accepted. None is dropped and none is duplicated.
- R4: While out_valid=1 and out_stop=1 at an edge (retry), out_valid stays 1 and out_data keeps its value after that edge.
- R5: in_stop is 1 exactly when two tokens are held, and it changes only at a rising edge.
- R6: With in_valid held at 1 and out_stop held at 0, the stage accepts and delivers one token every cycle and never raises in_stop.
- R7: An input presented while in_stop=1 is not stored. The tokens already held, and the number later delivered, are unchanged by it.
- R8: A change of out_stop between edges has no effect on in_stop before the next rising edge.
- R9: Idle input cycles (in_valid=0) store nothing, whatever in_data carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset, empties the stage |
| in_data | input | DATA_W | Token payload from the sender |
| in_valid | input | 1 | Sender offers a token |
| in_stop | output | 1 | Registered back-pressure to the sender, high when both slots are in use |
| out_data | output | DATA_W | Oldest held token |
| out_valid | output | 1 | At least one token is held |
| out_stop | input | 1 | Back-pressure from the receiver |

## Verification
Embedded properties watch, on every cycle, that occupancy never exceeds two, that the upstream stop agrees with a full stage, that a blocked cycle on both sides leaves the pointer state untouched, and that a retried output token stays valid and unchanged. Token order, the absence of loss or duplication, one-cycle latency, full-rate streaming and the purely registered nature of the upstream stop can only be shown by the directed scenarios. Those scenarios compare delivered tokens against a queue model and toggle out_stop between edges while watching in_stop.

// File: rtl/eb2_pkg.sv
package eb2_pkg;

    localparam int SLOTS = 2;
    localparam int PTR_W = 1;
    localparam int CNT_W = $clog2(SLOTS + 1);

    typedef logic [PTR_W-1:0] ptr_t;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_XFER  = 2'd1,
        CH_RETRY = 2'd2
    } ch_cond_e;

    typedef struct packed {
        ptr_t wr;
        ptr_t rd;
        cnt_t cnt;
    } occ_t;

    function automatic ch_cond_e ch_classify(logic valid, logic stop);
        if (!valid)
            return CH_IDLE;
        else if (stop)
            return CH_RETRY;
        else
            return CH_XFER;
    endfunction

    function automatic ptr_t ptr_next(ptr_t p);
        if (p == ptr_t'(SLOTS - 1))
            return '0;
        else
            return p + ptr_t'(1);
    endfunction

endpackage

// File: rtl/eb2_ctrl.sv
module eb2_ctrl
    import eb2_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic out_stop,
    output logic push,
    output logic pop,
    output ptr_t wr_ptr,
    output ptr_t rd_ptr,
    output logic out_valid,
    output logic in_stop
);

    occ_t     st_q;
    occ_t     st_d;
    logic     stop_q;
    ch_cond_e in_cond;
    ch_cond_e out_cond;

    assign out_valid = (st_q.cnt != '0);
    assign in_stop   = stop_q;
    assign wr_ptr    = st_q.wr;
    assign rd_ptr    = st_q.rd;

    always_comb begin
        in_cond  = ch_classify(in_valid, stop_q);
        out_cond = ch_classify(out_valid, out_stop);
        push     = (in_cond == CH_XFER);
        pop      = (out_cond == CH_XFER);
    end

    always_comb begin
        st_d = st_q;
        if (push)
            st_d.wr = ptr_next(st_q.wr);
        if (pop)
            st_d.rd = ptr_next(st_q.rd);
        st_d.cnt = st_q.cnt + cnt_t'(push) - cnt_t'(pop);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '0;
            stop_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            stop_q <= (st_d.cnt == cnt_t'(SLOTS));
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= cnt_t'(SLOTS)) else $error("occupancy overflow"); // R5

    AST_STOP_MATCHES_FULL: assert property (@(posedge clk) disable iff (rst)
        stop_q == (st_q.cnt == cnt_t'(SLOTS))) else $error("stop out of step"); // R5

    AST_BLOCKED_HOLDS_STATE: assert property (@(posedge clk) disable iff (rst)
        (stop_q && out_stop) |=> $stable(st_q)) else $error("blocked stage moved"); // R7

    AST_RETRY_KEEPS_VALID: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_stop) |=> out_valid) else $error("retried token vanished"); // R4

    AST_PTR_GAP: assert property (@(posedge clk) disable iff (rst)
        (st_q.cnt == cnt_t'(1)) |-> (st_q.wr != st_q.rd)) else $error("pointer gap"); // R3

endmodule

// File: rtl/eb2_store.sv
module eb2_store
    import eb2_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              push,
    input  ptr_t              wr_ptr,
    input  ptr_t              rd_ptr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] slot_q [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && (wr_ptr == ptr_t'(g)))
                slot_q[g] <= wr_data;
        end
    end

    assign rd_data = slot_q[rd_ptr];

endmodule

// File: rtl/elastic_buf2.sv
module elastic_buf2
    import eb2_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_stop,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_stop
);

    logic push;
    logic pop;
    ptr_t wr_ptr;
    ptr_t rd_ptr;

    eb2_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .out_stop (out_stop),
        .push     (push),
        .pop      (pop),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .out_valid(out_valid),
        .in_stop  (in_stop)
    );

    eb2_store #(.DATA_W(DATA_W)) u_store (
        .clk    (clk),
        .push   (push),
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr),
        .wr_data(in_data),
        .rd_data(out_data)
    );

    AST_RETRY_DATA_STABLE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_stop) |=> $stable(out_data)) else $error("retried data changed"); // R4

    AST_FULL_IMPLIES_VALID: assert property (@(posedge clk) disable iff (rst)
        in_stop |-> out_valid) else $error("stop while empty"); // R5

    AST_POP_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        pop |-> (out_valid && !out_stop)) else $error("pop without transfer"); // R3

endmodule

// File: tb/elastic_buf2_tb.sv
module elastic_buf2_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic [DW-1:0] in_data;
    logic          in_valid;
    logic          in_stop;
    logic [DW-1:0] out_data;
    logic          out_valid;
    logic          out_stop;

    int            n_chk = 0;
    int            n_err = 0;
    int            popped = 0;
    logic [DW-1:0] model[$];
    logic          prev_retry = 1'b0;
    logic [DW-1:0] prev_data = '0;
    logic [DW-1:0] tok = 16'h0100;

    elastic_buf2 #(.DATA_W(DW)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .in_data  (in_data),
        .in_valid (in_valid),
        .in_stop  (in_stop),
        .out_data (out_data),
        .out_valid(out_valid),
        .out_stop (out_stop)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // drive one cycle of inputs between edges; update the model from the settled outputs
    task automatic step(logic v, logic [DW-1:0] d, logic s);
        @(negedge clk);
        in_valid = v;
        in_data  = d;
        out_stop = s;
        #1;
        if (prev_retry) begin
            chk(out_valid == 1'b1, "R4 valid held", out_valid, 1);
            chk(out_data == prev_data, "R4 data held", out_data, prev_data);
        end
        if (out_valid && !out_stop) begin
            if (model.size() == 0) begin
                chk(1'b0, "R3 extra token", out_data, 0);
            end else begin
                chk(out_data == model[0], "R3 order", out_data, model[0]);
                void'(model.pop_front());
            end
            popped++;
        end
        if (v && !in_stop)
            model.push_back(d);
        prev_retry = out_valid && out_stop;
        prev_data  = out_data;
    endtask

    task automatic drain();
        repeat (4) step(1'b0, '0, 1'b0);
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0; in_data = '0; out_stop = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        chk(in_stop == 1'b0, "R1 in_stop", in_stop, 0);
    endtask

    task automatic t_latency();
        drain();
        step(1'b1, 16'hA5A5, 1'b0);
        chk(out_valid == 1'b0, "R2 empty before edge", out_valid, 0);
        step(1'b0, '0, 1'b0);
        chk(out_valid == 1'b1, "R2 valid next cycle", out_valid, 1);
        chk(out_data == 16'hA5A5, "R2 data next cycle", out_data, 16'hA5A5);
        drain();
    endtask

    task automatic t_idle();
        drain();
        for (int i = 0; i < 4; i++) begin
            step(1'b0, 16'h7700 + DW'(i), 1'b0);
            chk(out_valid == 1'b0, "R9 idle stores nothing", out_valid, 0);
        end
        step(1'b0, '0, 1'b0);
        chk(out_valid == 1'b0, "R9 still empty", out_valid, 0);
    endtask

    task automatic t_stream();
        int start;
        bit stop_seen;
        drain();
        start = popped;
        stop_seen = 1'b0;
        for (int i = 0; i < 16; i++) begin
            step(1'b1, 16'h3000 + DW'(i), 1'b0);
            if (in_stop) stop_seen = 1'b1;
            if (i > 0) chk(out_valid == 1'b1, "R6 valid every cycle", out_valid, 1);
        end
        chk(stop_seen == 1'b0, "R6 no stop while streaming", stop_seen, 0);
        chk(popped - start == 15, "R6 one token per cycle", popped - start, 15);
        drain();
    endtask

    task automatic t_backpressure();
        int start;
        drain();
        start = popped;
        step(1'b1, 16'hB001, 1'b1);
        chk(in_stop == 1'b0, "R5 stop low when empty", in_stop, 0);
        step(1'b1, 16'hB002, 1'b1);
        chk(in_stop == 1'b0, "R5 stop low with one", in_stop, 0);
        // R8: stop into the stage changes, stop out must not follow before the edge
        out_stop = 1'b0; #1;
        chk(in_stop == 1'b0, "R8 no comb path (one held)", in_stop, 0);
        out_stop = 1'b1; #1;
        step(1'b1, 16'hB003, 1'b1);
        chk(in_stop == 1'b1, "R5 stop high when two held", in_stop, 1);
        out_stop = 1'b0; #1;
        chk(in_stop == 1'b1, "R8 no comb path (full)", in_stop, 1);
        out_stop = 1'b1; #1;
        step(1'b1, 16'hB003, 1'b1);
        chk(in_stop == 1'b1, "R7 full stays full", in_stop, 1);
        chk(out_data == 16'hB001, "R7 oldest unchanged", out_data, 16'hB001);
        drain();
        chk(popped - start == 2, "R7 blocked token not stored", popped - start, 2);
        chk(out_valid == 1'b0, "R7 drained empty", out_valid, 0);
    endtask

    task automatic t_random();
        logic v = 1'b0;
        logic [DW-1:0] d = '0;
        logic blocked = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            if (!blocked) begin
                v = ($urandom % 3) != 0;
                if (v) begin
                    tok = tok + 1'b1;
                    d = tok;
                end
            end
            step(v, d, ($urandom % 2) == 1);
            blocked = v && in_stop;
        end
        repeat (6) step(1'b0, '0, 1'b0);
        chk(model.size() == 0, "R3 nothing lost", model.size(), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_latency();
        t_idle();
        t_stream();
        t_backpressure();
        t_random();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule